// File: doc/BRIEF.md
# Host Mailbox Flag and Interrupt Registers

This block is a small register file that a host reaches through a simple single-cycle read/write port. It keeps track of which shared per-port packet buffers belong to the host and which belong to a device-side engine. A single flags word holds two fields. The low field holds one "transmit busy" bit per port. The host sets a bit by writing 1 when it hands a transmit buffer to the device, and the device clears it with a "consumed" strobe. The next field holds one "receive ready" bit per port. The device sets a bit with a "filled" strobe, and the host clears it by writing 1 once the buffer is drained. Writing 0 to any flags bit leaves it unchanged.

Every device strobe also latches an interrupt-pending bit. Any write to the acknowledge word drops the pending bit. A host-controlled enable bit gates it onto a level interrupt line. The host usually turns the enable off on entry to its handler and back on at exit, and an event still pending at that moment raises the line again. A read-only version word reports major, minor and build numbers. Start-up software zeroes every word and then writes 0xF0 to the flags word. None of that disturbs the version word.

Top module: `mbox_flag_regs`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every transmit-busy bit, receive-ready bit, the pending bit, the enable bit and reg_rdata are 0, and irq is 0.
- R2: A write to the flags word at byte offset 0x7C sets transmit-busy bit n (flags bit n, n < NUM_PORTS) wherever wdata bit n is 1. Bits written 0 keep their value.
- R3: A write to the flags word clears receive-ready bit n (flags bit 4+n) wherever wdata bit 4+n is 1. Bits written 0 keep their value.
- R4: A tx_consumed[n] pulse clears transmit-busy bit n, and an rx_filled[n] pulse sets receive-ready bit n, at the next clock edge.
- R5: On the same edge, a host set of transmit-busy bit n wins over tx_consumed[n], and rx_filled[n] wins over a host clear of receive-ready bit n.
- R6: Any tx_consumed or rx_filled pulse sets the pending bit. Any write to the acknowledge word at 0x70, whatever its data, clears it. A pulse on the same edge as the acknowledge leaves pending set. The acknowledge word reads 0.
- R7: The enable bit is wdata bit 0 of a write to 0x78 and reads back at bit 0 of that word. irq is high exactly when pending and enable are both 1, so irq returns when enable is set again while pending is still 1.
- R8: The word at 0x74 reads {VER_MAJOR[31:24], VER_MINOR[23:16], VER_BUILD[15:0]}. Writes to it have no effect.
- R9: Reads of any other offset, including a byte address with bits [1:0] non-zero, return 0, and writes to such offsets change no state. Flags bits for ports at or above NUM_PORTS and flags bits [31:8] read 0 and cannot be set.
- R10: reg_rdata takes the value of the addressed word at the clock edge where reg_ren is sampled high, using the state before that edge's write. It holds its value while reg_ren is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 7 | Byte address within the 128-byte space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tx_consumed | input | NUM_PORTS | Device finished with transmit buffer n |
| rx_filled | input | NUM_PORTS | Device filled receive buffer n |
| irq | output | 1 | Level interrupt, pending AND enable |

## Verification
The flags word is first exercised with directed patterns. Set-only and clear-only writes separate the write-1-to-set field from the write-1-to-clear field. All-ones writes expose bits of unused ports. Strobes on the same edge as host writes tell the two priority rules apart. The interrupt path is driven through acknowledge alone, acknowledge together with a strobe, and an enable toggle with an event still pending, which distinguishes a lost event from a correct re-assertion. A long seeded random mix of reads, writes and strobes over mapped, unmapped and misaligned offsets then compares every read and the interrupt line on every cycle against a bench model.

// File: rtl/mbox_pkg.sv
// Package: shared constants and types for the mailbox register block.
// Assumes a 128-byte space of 32-bit words addressed by byte.
package mbox_pkg;
    localparam int CFG_ADDR_W = 7;
    localparam int CFG_DATA_W = 32;
    localparam int FIELD_W    = 4;   // width reserved for each per-port field

    localparam logic [CFG_ADDR_W-1:0] OFS_ACK   = 7'h70;
    localparam logic [CFG_ADDR_W-1:0] OFS_VER   = 7'h74;
    localparam logic [CFG_ADDR_W-1:0] OFS_EN    = 7'h78;
    localparam logic [CFG_ADDR_W-1:0] OFS_FLAGS = 7'h7C;

    typedef struct packed {
        logic flags;
        logic en;
        logic ver;
        logic ack;
    } mbox_sel_t;
endpackage

// File: rtl/mbox_reg_decode.sv
// Module: address decoder. Turns a byte address into one-hot word selects.
// Assumes only word-aligned addresses hit; misaligned ones select nothing.
module mbox_reg_decode
    import mbox_pkg::*;
(
    input  logic [CFG_ADDR_W-1:0] addr,
    output mbox_sel_t             sel
);
    // Compare the address against each mapped offset
    always_comb begin
        sel       = '0;
        sel.flags = (addr == OFS_FLAGS);
        sel.en    = (addr == OFS_EN);
        sel.ver   = (addr == OFS_VER);
        sel.ack   = (addr == OFS_ACK);
    end
endmodule

// File: rtl/mbox_flag_bank.sv
// Module: per-port ownership flags. Transmit-busy is set by the host and
// cleared by the device. Receive-ready is set by the device and cleared by
// the host. Assumes NUM_PORTS <= FIELD_W.
module mbox_flag_bank
    import mbox_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [NUM_PORTS-1:0] host_set,
    input  logic [NUM_PORTS-1:0] host_clr,
    input  logic [NUM_PORTS-1:0] dev_consumed,
    input  logic [NUM_PORTS-1:0] dev_filled,
    output logic [NUM_PORTS-1:0] tx_busy,
    output logic [NUM_PORTS-1:0] rx_ready
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Transmit-busy bit: host set wins over device consume
        always_ff @(posedge clk) begin
            if (!rst_n)
                tx_busy[p] <= 1'b0;
            else if (host_wr && host_set[p])
                tx_busy[p] <= 1'b1;
            else if (dev_consumed[p])
                tx_busy[p] <= 1'b0;
        end

        // Receive-ready bit: device fill wins over host clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                rx_ready[p] <= 1'b0;
            else if (dev_filled[p])
                rx_ready[p] <= 1'b1;
            else if (host_wr && host_clr[p])
                rx_ready[p] <= 1'b0;
        end
    end
endmodule

// File: rtl/mbox_irq_ctrl.sv
// Module: interrupt pending latch, enable bit and gated level output.
// Assumes device events arrive as single-cycle strobes.
module mbox_irq_ctrl #(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_wr,
    input  logic                 en_wr,
    input  logic                 en_wdata,
    input  logic [NUM_PORTS-1:0] dev_consumed,
    input  logic [NUM_PORTS-1:0] dev_filled,
    output logic                 pending,
    output logic                 enable,
    output logic                 irq
);
    logic any_event;

    // Any device strobe is an interrupt event
    always_comb any_event = (|dev_consumed) | (|dev_filled);

    // Pending latch: events beat acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (any_event)
            pending <= 1'b1;
        else if (ack_wr)
            pending <= 1'b0;
    end

    // Host interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (en_wr)
            enable <= en_wdata;
    end

    // Level output gated by enable
    always_comb irq = pending & enable;
endmodule

// File: rtl/mbox_flag_regs.sv
// Module: top of the mailbox register block. Decodes the host port, holds
// flags and interrupt state, and returns registered read data.
// Assumes a single-cycle read/write port with no wait states.
module mbox_flag_regs
    import mbox_pkg::*;
#(
    parameter int          NUM_PORTS = 2,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd2,
    parameter logic [15:0] VER_BUILD = 16'd345
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wen,
    input  logic                  reg_ren,
    input  logic [CFG_ADDR_W-1:0] reg_addr,
    input  logic [CFG_DATA_W-1:0] reg_wdata,
    output logic [CFG_DATA_W-1:0] reg_rdata,
    input  logic [NUM_PORTS-1:0]  tx_consumed,
    input  logic [NUM_PORTS-1:0]  rx_filled,
    output logic                  irq
);
    localparam logic [CFG_DATA_W-1:0] VERSION_WORD = {VER_MAJOR, VER_MINOR, VER_BUILD};

    mbox_sel_t             sel;
    logic [NUM_PORTS-1:0]  tx_busy_q;
    logic [NUM_PORTS-1:0]  rx_ready_q;
    logic                  irq_pend_q;
    logic                  irq_en_q;
    logic [CFG_DATA_W-1:0] flags_word;
    logic [CFG_DATA_W-1:0] rd_mux;

    mbox_reg_decode u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    mbox_flag_bank #(.NUM_PORTS(NUM_PORTS)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (reg_wen && sel.flags),
        .host_set     (reg_wdata[NUM_PORTS-1:0]),
        .host_clr     (reg_wdata[FIELD_W +: NUM_PORTS]),
        .dev_consumed (tx_consumed),
        .dev_filled   (rx_filled),
        .tx_busy      (tx_busy_q),
        .rx_ready     (rx_ready_q)
    );

    mbox_irq_ctrl #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_wr       (reg_wen && sel.ack),
        .en_wr        (reg_wen && sel.en),
        .en_wdata     (reg_wdata[0]),
        .dev_consumed (tx_consumed),
        .dev_filled   (rx_filled),
        .pending      (irq_pend_q),
        .enable       (irq_en_q),
        .irq          (irq)
    );

    // Assemble the flags word with unused port bits tied to zero
    always_comb begin
        flags_word                       = '0;
        flags_word[NUM_PORTS-1:0]        = tx_busy_q;
        flags_word[FIELD_W +: NUM_PORTS] = rx_ready_q;
    end

    // Select read data; unmapped and acknowledge offsets read zero
    always_comb begin
        rd_mux = '0;
        if (sel.flags)    rd_mux = flags_word;
        else if (sel.en)  rd_mux = {{(CFG_DATA_W-1){1'b0}}, irq_en_q};
        else if (sel.ver) rd_mux = VERSION_WORD;
    end

    // Register read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_ren)
            reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/mbox_flag_regs_chk.sv
// Module: property checker for the mailbox register block, bound to the top.
module mbox_flag_regs_chk
    import mbox_pkg::*;
#(
    parameter int          NUM_PORTS = 2,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd2,
    parameter logic [15:0] VER_BUILD = 16'd345
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wen,
    input logic                  reg_ren,
    input logic [CFG_ADDR_W-1:0] reg_addr,
    input logic [CFG_DATA_W-1:0] reg_wdata,
    input logic [CFG_DATA_W-1:0] reg_rdata,
    input logic [NUM_PORTS-1:0]  tx_consumed,
    input logic [NUM_PORTS-1:0]  rx_filled,
    input logic                  irq,
    input logic [NUM_PORTS-1:0]  tx_busy_q,
    input logic [NUM_PORTS-1:0]  rx_ready_q,
    input logic                  irq_pend_q
);
    logic                 flags_wr;
    logic [NUM_PORTS-1:0] set_req;
    logic                 unmapped;

    // Independent view of host flag writes and unmapped offsets
    always_comb begin
        flags_wr = reg_wen && (reg_addr == 7'h7C);
        set_req  = flags_wr ? reg_wdata[NUM_PORTS-1:0] : '0;
        unmapped = !(reg_addr inside {7'h70, 7'h74, 7'h78, 7'h7C});
    end

    // R2: host write of 1 marks transmit buffer busy
    a_r2_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req != '0) |=> ((tx_busy_q & $past(set_req)) == $past(set_req)));

    // R4: consume without a host set frees the buffer
    a_r4_tx_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_consumed & ~set_req) != '0) |=> ((tx_busy_q & $past(tx_consumed & ~set_req)) == '0));

    // R4 and R5: a fill always marks receive ready
    a_r5_rx_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_filled != '0) |=> ((rx_ready_q & $past(rx_filled)) == $past(rx_filled)));

    // R6: any event latches pending
    a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_consumed != '0) || (rx_filled != '0)) |=> irq_pend_q);

    // R7: disabling the enable silences the line
    a_r7_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 7'h78 && !reg_wdata[0]) |=> !irq);

    // R7: the line never rises without pending
    a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_pend_q);

    // R8: version word read
    a_r8_version: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ren && reg_addr == 7'h74) |=> (reg_rdata == {VER_MAJOR, VER_MINOR, VER_BUILD}));

    // R9: unmapped reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ren && unmapped) |=> (reg_rdata == '0));

    // R10: read data holds without a read strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ren && $past(rst_n)) |=> $stable(reg_rdata));
endmodule

bind mbox_flag_regs mbox_flag_regs_chk #(
    .NUM_PORTS (NUM_PORTS),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR),
    .VER_BUILD (VER_BUILD)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wen     (reg_wen),
    .reg_ren     (reg_ren),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tx_consumed (tx_consumed),
    .rx_filled   (rx_filled),
    .irq         (irq),
    .tx_busy_q   (tx_busy_q),
    .rx_ready_q  (rx_ready_q),
    .irq_pend_q  (irq_pend_q)
);

// File: tb/mbox_flag_regs_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, every cycle
// compared against a bench model of the register behaviour.
module mbox_flag_regs_tb_top;
    localparam int          P     = 2;
    localparam logic [7:0]  MAJ   = 8'd1;
    localparam logic [7:0]  MIN   = 8'd2;
    localparam logic [15:0] BLD   = 16'd345;
    localparam logic [31:0] VERW  = {MAJ, MIN, BLD};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic        reg_ren = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [P-1:0] tx_consumed = '0;
    logic [P-1:0] rx_filled = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state
    logic [P-1:0] m_tx = '0, m_rx = '0;
    logic         m_pend = 0, m_en = 0;
    logic [31:0]  m_rdata = '0;

    always #2.5 clk = ~clk;

    mbox_flag_regs #(.NUM_PORTS(P), .VER_MAJOR(MAJ), .VER_MINOR(MIN), .VER_BUILD(BLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_ren(reg_ren),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_consumed(tx_consumed), .rx_filled(rx_filled), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [6:0] a);
        logic [31:0] w = '0;
        case (a)
            7'h7C: begin w[P-1:0] = m_tx; w[4 +: P] = m_rx; end
            7'h78: w[0] = m_en;
            7'h74: w = VERW;
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, advance model at posedge, check after it
    task automatic step(input string tag, input logic wen, input logic ren,
                        input logic [6:0] a, input logic [31:0] d,
                        input logic [P-1:0] cons, input logic [P-1:0] fill);
        logic [P-1:0] setm, clrm;
        @(negedge clk);
        reg_wen = wen; reg_ren = ren; reg_addr = a; reg_wdata = d;
        tx_consumed = cons; rx_filled = fill;
        @(posedge clk);
        setm = (wen && a == 7'h7C) ? d[P-1:0] : '0;
        clrm = (wen && a == 7'h7C) ? d[4 +: P] : '0;
        if (ren) m_rdata = model_read(a);
        m_tx = (m_tx & ~cons) | setm;
        m_rx = (m_rx & ~clrm) | fill;
        if ((|cons) || (|fill)) m_pend = 1'b1;
        else if (wen && a == 7'h70) m_pend = 1'b0;
        if (wen && a == 7'h78) m_en = d[0];
        #1;
        check({tag, " rdata"}, reg_rdata, m_rdata);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_pend & m_en});
    endtask

    task automatic wr(input string tag, input logic [6:0] a, input logic [31:0] d);
        step(tag, 1'b1, 1'b0, a, d, '0, '0);
    endtask

    task automatic rd(input string tag, input logic [6:0] a);
        step(tag, 1'b0, 1'b1, a, '0, '0, '0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd("R1 flags", 7'h7C);
        rd("R1 enable", 7'h78);

        // Start-up sequence: zero every word, then clear receive slots
        for (int i = 0; i < 32; i++) wr("R9 zero fill", 7'(i * 4), 32'h0);
        wr("R3 startup", 7'h7C, 32'h0000_00F0);
        rd("R8 version after zero fill", 7'h74);

        // R2: set tx bits, zeros leave them alone
        wr("R2 set", 7'h7C, 32'h1);
        wr("R2 set2", 7'h7C, 32'h2);
        wr("R2 zeros", 7'h7C, 32'h0);
        rd("R2 read", 7'h7C);
        // R9: unused port and high bits cannot be set
        wr("R9 all ones", 7'h7C, 32'hFFFF_FF0C);
        rd("R9 inactive bits", 7'h7C);

        // R4: device strobes
        step("R4 fill1", 0, 0, 7'h0, 0, 2'b00, 2'b10);
        step("R4 consume0", 0, 1, 7'h7C, 0, 2'b01, 2'b00);
        rd("R4 read", 7'h7C);

        // R3: clear rx bit, zero write leaves other rx alone
        step("R3 fill0", 0, 0, 7'h0, 0, 2'b00, 2'b01);
        wr("R3 clear1", 7'h7C, 32'h20);
        rd("R3 read", 7'h7C);

        // R5: same-edge priority
        step("R5 set vs consume", 1, 0, 7'h7C, 32'h1, 2'b01, 2'b00);
        step("R5 fill vs clear", 1, 0, 7'h7C, 32'h30, 2'b00, 2'b10);
        rd("R5 read", 7'h7C);

        // R6 and R7: pending, acknowledge, enable gating
        wr("R7 enable on", 7'h78, 32'h1);
        rd("R7 enable read", 7'h78);
        wr("R6 ack", 7'h70, 32'h0);
        step("R6 event", 0, 0, 7'h0, 0, 2'b10, 2'b00);
        step("R6 ack with event", 1, 0, 7'h70, 32'hDEAD, 2'b00, 2'b01);
        wr("R7 enable off", 7'h78, 32'h0);
        wr("R7 enable on again", 7'h78, 32'hFFFF_FFFF);
        wr("R6 ack clears", 7'h70, 32'h1234);
        rd("R6 ack reads zero", 7'h70);

        // R8: version word, write ignored
        wr("R8 write", 7'h74, 32'hFFFF_FFFF);
        rd("R8 read", 7'h74);

        // R9: unmapped and misaligned
        wr("R9 unmapped write", 7'h00, 32'hFFFF_FFFF);
        wr("R9 misaligned write", 7'h7D, 32'hFFFF_FFFF);
        rd("R9 misaligned read", 7'h7D);
        rd("R9 flags after", 7'h7C);

        // R10: hold while not reading, then same-edge read sees old state
        step("R10 hold", 0, 0, 7'h74, 0, 2'b00, 2'b00);
        step("R10 read before write", 1, 1, 7'h7C, 32'h3, 2'b00, 2'b00);
        rd("R10 read after write", 7'h7C);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [6:0] a;
            int k = $urandom_range(0, 9);
            case (k)
                0, 1, 2: a = 7'h7C;
                3: a = 7'h78;
                4: a = 7'h74;
                5: a = 7'h70;
                default: a = 7'($urandom_range(0, 127));
            endcase
            step("R4 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                 $urandom(), ($urandom_range(0, 5) == 0) ? P'($urandom()) : '0,
                 ($urandom_range(0, 5) == 0) ? P'($urandom()) : '0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule